// File: doc/BRIEF.md
# Configurable Payload Down-Sampler

This block sits right behind clock and data recovery in a terminal that receives a bit-interleaved downstream stream, with one line bit per clock. Two markers frame the stream: one opens each frame's header, the other opens its payload. Within the payload, only a sparse, evenly spaced subset of bits belongs to this terminal. The block picks out those bits and presents each one with a strobe and its position inside the payload. It also drives a clock enable, so logic behind it can stay idle whenever it has nothing to receive.

The allocation is a pair: a first position and a spacing. Each frame's bandwidth map supplies a new pair. Another unit parses that map and delivers the pair on a load pulse. The block holds the pair in a pending set and moves it into the working set when the next payload starts. Any change therefore lines up with a payload boundary. A spacing of zero means this terminal has no allocation in that payload. A sleep input blanks the output, but the payload bit count keeps running underneath, so the sampling grid stays aligned.

Top module: `payload_sampler`

## Requirements
- R1: While reset is high, and after it until the first payload begins, `smp_vld` and `smp_cke` are 0. The working allocation after reset has spacing 0, so a payload with no prior load yields nothing.
- R2: The first bit taken from a payload is the one at payload position S, where position 0 is the bit presented together with `pay_start`. `smp_pos` equals S and `smp_bit` equals that line bit.
- R3: After the first bit, the block takes every K-th payload bit (positions S+K, S+2K, ...) until the next `frame_start`. Each output appears one clock after its bit is presented.
- R4: With S=0 and K=1, the block takes every payload bit, starting with the one presented together with `pay_start`.
- R5: `smp_cke` is 1 exactly one clock after each payload cycle in which K is nonzero and `sleep_req` is 0, and 0 otherwise. `smp_vld` is never 1 while `smp_cke` is 0.
- R6: A spacing K of 0 means no allocation: for that whole payload, `smp_vld` and `smp_cke` stay 0.
- R7: One clock after any cycle with `sleep_req` high, `smp_vld` and `smp_cke` are 0. The position count keeps running during sleep, so bits taken after sleep still lie on the S + nK grid.
- R8: Header bits never produce output. From `frame_start` until `pay_start`, `smp_vld` and `smp_cke` are 0 one clock later.
- R9: A `cfg_load` pulse only stores S and K as pending values. They take effect at the next `pay_start`, and a load during a payload leaves that payload's grid unchanged.
- R10: When `cfg_load` and `pay_start` coincide, the payload starting in that cycle uses the previously pending values. The newly loaded values apply from the following payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_bit | input | 1 | Recovered serial line bit |
| frame_start | input | 1 | Marks the first header bit of a frame |
| pay_start | input | 1 | Marks payload position 0 |
| sleep_req | input | 1 | Suppresses output and enable while high |
| cfg_load | input | 1 | Stores cfg_start and cfg_rate as pending allocation |
| cfg_start | input | ALLOC_W | First payload position S |
| cfg_rate | input | ALLOC_W | Spacing K; 0 means no allocation |
| smp_bit | output | 1 | Extracted bit |
| smp_vld | output | 1 | Strobe for smp_bit |
| smp_pos | output | POS_W | Payload position of the extracted bit |
| smp_cke | output | 1 | Clock enable for downstream logic |

## Verification
The checker watches several conditions on every cycle: the strobe never fires without the enable, sleep and header cycles give a blank output one clock later, and reset clears both outputs. The spacing of the sampling grid, the position of each bit and its value, and the hand-over from pending to working allocation depend on which values were loaded and when. Only the bench's frame scenarios can show those. The scenarios cover a load during a payload, a load coinciding with the payload marker, a zero spacing and a sleep window.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int ALLOC_W = 16;

  typedef struct packed {
    logic [ALLOC_W-1:0] start;
    logic [ALLOC_W-1:0] rate;
  } alloc_t;
endpackage

// File: rtl/ps_alloc_regs.sv
// Pending and working allocation sets; the working set changes only at payload start.
module ps_alloc_regs
  import ps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cfg_load,
  input  alloc_t cfg_in,
  input  logic   pay_start,
  output alloc_t alloc_eff
);
  alloc_t pend_q;
  alloc_t work_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      work_q <= '0;
    end else begin
      if (cfg_load) pend_q <= cfg_in;
      if (pay_start) work_q <= pend_q;
    end
  end

  // At the payload marker the pending set applies in the same cycle.
  assign alloc_eff = pay_start ? pend_q : work_q;
endmodule

// File: rtl/ps_grid.sv
// Payload position counter and gap countdown that finds sampling points.
module ps_grid
  import ps_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             pay_start,
  input  alloc_t           alloc_eff,
  output logic             hit,
  output logic             live,
  output logic [POS_W-1:0] pos_eff
);
  logic             in_pay_q;
  logic             in_pay_eff;
  logic [POS_W-1:0] pos_q;
  logic [ALLOC_W-1:0] gap_q;
  logic [ALLOC_W-1:0] gap_eff;
  logic             has_alloc;

  assign in_pay_eff = pay_start | (in_pay_q & ~frame_start);
  assign pos_eff    = pay_start ? '0 : pos_q;
  assign gap_eff    = pay_start ? alloc_eff.start : gap_q;
  assign has_alloc  = (alloc_eff.rate != '0);
  assign live       = in_pay_eff & has_alloc;
  assign hit        = live & (gap_eff == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pay_q <= 1'b0;
      pos_q    <= '0;
      gap_q    <= '0;
    end else begin
      in_pay_q <= in_pay_eff;
      if (in_pay_eff) begin
        pos_q <= pos_eff + 1'b1;
        gap_q <= (gap_eff == '0) ? (alloc_eff.rate - 1'b1) : (gap_eff - 1'b1);
      end
    end
  end
endmodule

// File: rtl/ps_out_stage.sv
// Registered outputs; sleep blanks strobe and enable without touching the grid.
module ps_out_stage #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             live,
  input  logic             sleep_req,
  input  logic             line_bit,
  input  logic [POS_W-1:0] pos_eff,
  output logic             smp_bit,
  output logic             smp_vld,
  output logic [POS_W-1:0] smp_pos,
  output logic             smp_cke
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_bit <= 1'b0;
      smp_vld <= 1'b0;
      smp_pos <= '0;
      smp_cke <= 1'b0;
    end else begin
      smp_vld <= hit & ~sleep_req;
      smp_cke <= live & ~sleep_req;
      if (hit & ~sleep_req) begin
        smp_bit <= line_bit;
        smp_pos <= pos_eff;
      end
    end
  end
endmodule

// File: rtl/payload_sampler.sv
module payload_sampler
  import ps_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_bit,
  input  logic               frame_start,
  input  logic               pay_start,
  input  logic               sleep_req,
  input  logic               cfg_load,
  input  logic [ALLOC_W-1:0] cfg_start,
  input  logic [ALLOC_W-1:0] cfg_rate,
  output logic               smp_bit,
  output logic               smp_vld,
  output logic [POS_W-1:0]   smp_pos,
  output logic               smp_cke
);
  alloc_t           cfg_in;
  alloc_t           alloc_eff;
  logic             hit;
  logic             live;
  logic [POS_W-1:0] pos_eff;

  assign cfg_in.start = cfg_start;
  assign cfg_in.rate  = cfg_rate;

  ps_alloc_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_in    (cfg_in),
    .pay_start (pay_start),
    .alloc_eff (alloc_eff)
  );

  ps_grid #(.POS_W(POS_W)) u_grid (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .pay_start   (pay_start),
    .alloc_eff   (alloc_eff),
    .hit         (hit),
    .live        (live),
    .pos_eff     (pos_eff)
  );

  ps_out_stage #(.POS_W(POS_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .live      (live),
    .sleep_req (sleep_req),
    .line_bit  (line_bit),
    .pos_eff   (pos_eff),
    .smp_bit   (smp_bit),
    .smp_vld   (smp_vld),
    .smp_pos   (smp_pos),
    .smp_cke   (smp_cke)
  );
endmodule

// File: rtl/payload_sampler_chk.sv
module payload_sampler_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic pay_start,
  input logic sleep_req,
  input logic smp_vld,
  input logic smp_cke
);
  // R1: reset clears strobe and enable
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!smp_vld && !smp_cke));

  // R5: strobe never without enable
  assert_vld_has_cke_R5: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> smp_cke);

  // R7: sleep blanks output on the next cycle
  assert_sleep_blank_R7: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> (!smp_vld && !smp_cke));

  // R8: frame marker without payload marker opens header, no output
  assert_header_blank_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !pay_start) |=> (!smp_vld && !smp_cke));
endmodule

bind payload_sampler payload_sampler_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .pay_start   (pay_start),
  .sleep_req   (sleep_req),
  .smp_vld     (smp_vld),
  .smp_cke     (smp_cke)
);

// File: tb/sim_payload_sampler.sv
module sim_payload_sampler;
  localparam int POS_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_bit = 1'b0, frame_start = 1'b0, pay_start = 1'b0, sleep_req = 1'b0;
  logic cfg_load = 1'b0;
  logic [15:0] cfg_start = '0, cfg_rate = '0;
  logic smp_bit, smp_vld, smp_cke;
  logic [POS_W-1:0] smp_pos;

  always #5 clk = ~clk;

  payload_sampler #(.POS_W(POS_W)) u0 (
    .clk(clk), .rst(rst), .line_bit(line_bit), .frame_start(frame_start),
    .pay_start(pay_start), .sleep_req(sleep_req), .cfg_load(cfg_load),
    .cfg_start(cfg_start), .cfg_rate(cfg_rate), .smp_bit(smp_bit),
    .smp_vld(smp_vld), .smp_pos(smp_pos), .smp_cke(smp_cke)
  );

  typedef struct {
    int    pos;
    logic  b;
    string req;
  } exp_t;

  exp_t  sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  exp_cke_cur = 1'b0;
  logic  exp_cke_q = 1'b0;
  logic  mon_on = 1'b0;
  logic  finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string cke_req = "R1";

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: enable expectation is one clock behind the driver.
  always @(posedge clk) exp_cke_q <= exp_cke_cur;

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      check(smp_cke == exp_cke_q, {cke_req, " R5 enable"}, int'(smp_cke), int'(exp_cke_q));
      if (smp_vld) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R3 unexpected strobe", int'(smp_pos), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(smp_pos) == e.pos, {e.req, " position"}, int'(smp_pos), e.pos);
          check(smp_bit == e.b, {e.req, " bit"}, int'(smp_bit), int'(e.b));
        end
      end
    end
  end

  // Driver: one frame, header then payload; predicts outputs from the allocation in force.
  task automatic run_frame(input int hdr, input int pay, input int ld_at,
                           input int ld_s, input int ld_k, input int use_s,
                           input int use_k, input int slo, input int shi,
                           input string req);
    cke_req = req;
    for (int c = 0; c < hdr + pay; c++) begin
      int p;
      @(posedge clk); #1;
      p = c - hdr;
      frame_start = (c == 0);
      pay_start   = (c == hdr);
      cfg_load    = (c == ld_at);
      cfg_start   = 16'(ld_s);
      cfg_rate    = 16'(ld_k);
      sleep_req   = (c >= hdr) && (p >= slo) && (p <= shi);
      lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      line_bit    = lfsr[0];
      if (c >= hdr) begin
        exp_cke_cur = (use_k != 0) && !sleep_req;
        if (use_k != 0 && !sleep_req && p >= use_s && ((p - use_s) % use_k) == 0) begin
          exp_t e;
          e.pos = p; e.b = line_bit; e.req = req;
          sb_q.push_back(e);
        end
      end else begin
        exp_cke_cur = 1'b0;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!smp_vld && !smp_cke, "R1 reset outputs", int'(smp_vld) + int'(smp_cke), 0);
    @(posedge clk); #1 rst = 1'b0;
    mon_on = 1'b1;
    repeat (5) @(posedge clk);
    // R1: no load yet, spacing 0 after reset
    run_frame(8, 30, -1, 0, 0, 0, 0, -1, -2, "R1");
    // R2 R3: load in header, first at 3, then every 4th
    run_frame(10, 60, 2, 3, 4, 3, 4, -1, -2, "R2");
    // R9: load during payload leaves grid unchanged
    run_frame(10, 60, 25, 0, 1, 3, 4, -1, -2, "R9");
    // R4: pending 0/1 now applies
    run_frame(6, 40, -1, 0, 0, 0, 1, -1, -2, "R4");
    // R6: spacing zero
    run_frame(6, 40, 1, 5, 0, 5, 0, -1, -2, "R6");
    // R10: load coincides with payload marker, old pending (K=0) used
    run_frame(6, 40, 6, 2, 3, 5, 0, -1, -2, "R10");
    // R7: sleep window in payload, grid 2/3 continues after it
    run_frame(12, 60, -1, 0, 0, 2, 3, 10, 25, "R7");
    // R8 R3: long header then wider spacing
    run_frame(30, 50, 3, 7, 7, 7, 7, -1, -2, "R8");
    // closing header to end the last payload
    run_frame(10, 0, -1, 0, 0, 0, 0, -1, -2, "R8");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sb_q.size() == 0, "R3 missing strobes", sb_q.size(), 0);
    finish_run();
  end
endmodule